// File: doc/BRIEF.md
# Bitslice Arithmetic and Truth-Table Logic Unit

This block is a combinational datapath of identical one-bit slices. Every slice holds a full adder on a ripple carry chain and a two-input logic cell. The logic cell takes a four-bit function code as the truth table of its output, so any boolean function of the two operand bits can be built. Because the all-zero and all-one codes ignore the operands, the same cell also supplies constants. No operand multiplexer for immediates is needed.

A carry-enable control forces the carry that enters every slice to zero. The adder's sum then becomes the bitwise XOR of the operands, so addition and XOR share one input of the four-way result selector. The other three selector inputs are the logic cell, operand A and operand B. The carry travels between slices on a true rail and a complemented rail. The carry leaving the top slice is presented as a flag. Surrounding control logic drives the operands, function code, select field and carry controls, and captures the result and the flag.

Top module: `alu_bitslice`

## Requirements
- R1: With `carry_en`=1 and `res_sel`=00, `result` equals (`op_a` + `op_b` + `carry_in`) modulo 2^W.
- R2: With `carry_en`=1, `carry_out` equals bit W of the full sum `op_a` + `op_b` + `carry_in`.
- R3: With `carry_en`=0 and `res_sel`=00, `result` equals `op_a` XOR `op_b`, whatever the value of `carry_in`.
- R4: With `carry_en`=0, `carry_out` equals `op_a[W-1]` AND `op_b[W-1]`, whatever the value of `carry_in`.
- R5: With `res_sel`=01, each bit i of `result` equals `func[{op_a[i], op_b[i]}]`, where `op_a[i]` is the high bit of the two-bit index.
- R6: With `res_sel`=01, `func`=0000 gives all zeros and `func`=1111 gives all ones, for any operands.
- R7: `res_sel`=10 makes `result` equal `op_a`, and `res_sel`=11 makes `result` equal `op_b`.
- R8: `carry_out` follows the adder under R2 and R4 for every value of `res_sel`, including the logic and pass-through selections.
- R9: With `res_sel`=01, code 1000 gives AND, 1110 gives OR, 0110 gives XOR, 1100 gives `op_a` and 1010 gives `op_b`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | W | First operand |
| op_b | input | W | Second operand |
| func | input | 4 | Truth table of the logic cell, indexed by {a,b} |
| carry_en | input | 1 | 1 lets the carry ripple; 0 forces every slice's carry to zero |
| res_sel | input | 2 | Result source: 00 adder, 01 logic, 10 op_a, 11 op_b |
| carry_in | input | 1 | Carry into the lowest slice |
| result | output | W | Selected result word |
| carry_out | output | 1 | Carry leaving the top slice |

## Verification
The adder and the logic cell always work on the same operands at once, so the carry flag from the adder and a logic or pass-through result land together at the outputs. The bench provokes this by driving the logic and pass-through selections with both carry settings and random operands. It judges the result word against the truth-table or pass-through value and, in the same sample, the flag against the arithmetic carry. Carry-disabled cases with `carry_in` high check that the forced carry wins over the external one.

// File: rtl/alu_bs_pkg.sv
package alu_bs_pkg;

    localparam int SEL_W  = 2;
    localparam int FUNC_W = 4;

    typedef enum logic [SEL_W-1:0] {
        SEL_ARITH  = 2'b00,
        SEL_LOGIC  = 2'b01,
        SEL_PASS_A = 2'b10,
        SEL_PASS_B = 2'b11
    } res_sel_e;

    typedef struct packed {
        logic val;
        logic val_n;
    } rail_t;

    function automatic logic tt_lookup(input logic [FUNC_W-1:0] tt,
                                       input logic a, input logic b);
        return tt[{a, b}];
    endfunction

    function automatic logic maj3(input logic x, input logic y, input logic z);
        return (x & y) | (x & z) | (y & z);
    endfunction

endpackage

// File: rtl/alu_bs_adder_slice.sv
module alu_bs_adder_slice
    import alu_bs_pkg::*;
(
    input  logic  a,
    input  logic  b,
    input  rail_t c_in,
    input  logic  carry_en,
    output logic  sum,
    output rail_t c_out
);
    rail_t c_eff;

    always_comb begin
        c_eff.val   = carry_en & c_in.val;
        c_eff.val_n = ~carry_en | c_in.val_n;
        sum         = a ^ b ^ c_eff.val;
        c_out.val   = maj3(a, b, c_eff.val);
        c_out.val_n = maj3(~a, ~b, c_eff.val_n);
    end

    always_comb begin
        // R3: a disabled carry leaves the bare XOR on the sum
        if (!carry_en) a_r3_xor_when_disabled: assert (sum == (a ^ b));
        // R2: the two carry rails leaving the slice disagree
        a_r2_rails_complement: assert (c_out.val_n == ~c_out.val);
        // R4: with carry blocked, carry out is just a AND b
        if (!carry_en) a_r4_generate_only: assert (c_out.val == (a & b));
    end
endmodule

// File: rtl/alu_bs_logic_slice.sv
module alu_bs_logic_slice
    import alu_bs_pkg::*;
(
    input  logic [FUNC_W-1:0] func,
    input  logic              a,
    input  logic              b,
    output logic              y
);
    always_comb y = tt_lookup(func, a, b);

    always_comb begin
        // R6: constant codes ignore the operands
        if (func == 4'b0000) a_r6_const_zero: assert (y == 1'b0);
        if (func == 4'b1111) a_r6_const_one:  assert (y == 1'b1);
    end
endmodule

// File: rtl/alu_bs_result_sel.sv
module alu_bs_result_sel
    import alu_bs_pkg::*;
#(
    parameter int W = 16
) (
    input  res_sel_e      sel,
    input  logic [W-1:0]  arith,
    input  logic [W-1:0]  lgc,
    input  logic [W-1:0]  pass_a,
    input  logic [W-1:0]  pass_b,
    output logic [W-1:0]  y
);
    always_comb begin
        unique case (sel)
            SEL_ARITH:  y = arith;
            SEL_LOGIC:  y = lgc;
            SEL_PASS_A: y = pass_a;
            SEL_PASS_B: y = pass_b;
            default:    y = arith;
        endcase
    end
endmodule

// File: rtl/alu_bitslice.sv
module alu_bitslice
    import alu_bs_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0]      op_a,
    input  logic [W-1:0]      op_b,
    input  logic [FUNC_W-1:0] func,
    input  logic              carry_en,
    input  logic [SEL_W-1:0]  res_sel,
    input  logic              carry_in,
    output logic [W-1:0]      result,
    output logic              carry_out
);
    localparam int TOP = W - 1;

    rail_t        chain [W+1];
    logic [W-1:0] sum_w;
    logic [W-1:0] lgc_w;
    res_sel_e     sel_e;

    assign chain[0].val   = carry_in;
    assign chain[0].val_n = ~carry_in;
    assign sel_e          = res_sel_e'(res_sel);

    for (genvar i = 0; i < W; i++) begin : g_slice
        alu_bs_adder_slice u_add (
            .a        (op_a[i]),
            .b        (op_b[i]),
            .c_in     (chain[i]),
            .carry_en (carry_en),
            .sum      (sum_w[i]),
            .c_out    (chain[i+1])
        );
        alu_bs_logic_slice u_lgc (
            .func (func),
            .a    (op_a[i]),
            .b    (op_b[i]),
            .y    (lgc_w[i])
        );
    end

    alu_bs_result_sel #(.W(W)) u_sel (
        .sel    (sel_e),
        .arith  (sum_w),
        .lgc    (lgc_w),
        .pass_a (op_a),
        .pass_b (op_b),
        .y      (result)
    );

    assign carry_out = chain[W].val;

    always_comb begin
        // R7: pass-through selections reproduce the chosen operand
        if (res_sel == 2'b10) a_r7_pass_a: assert (result == op_a);
        if (res_sel == 2'b11) a_r7_pass_b: assert (result == op_b);
        // R4: top-slice flag with carry disabled
        if (!carry_en) a_r4_flag_generate: assert (carry_out == (op_a[TOP] & op_b[TOP]));
    end
endmodule

// File: tb/alu_bitslice_bench.sv
`timescale 1ns/1ps
module alu_bitslice_bench;
    localparam int W = 16;

    typedef struct {
        logic [W-1:0] res;
        logic         co;
        string        tag;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] op_a = '0, op_b = '0;
    logic [3:0]   func = '0;
    logic         carry_en = 1'b0;
    logic [1:0]   res_sel = '0;
    logic         carry_in = 1'b0;
    logic [W-1:0] result;
    logic         carry_out;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    exp_t q[$];

    always #4 clk = ~clk;

    alu_bitslice #(.W(W)) u_alu_bitslice (
        .op_a(op_a), .op_b(op_b), .func(func), .carry_en(carry_en),
        .res_sel(res_sel), .carry_in(carry_in),
        .result(result), .carry_out(carry_out)
    );

    function automatic logic [W:0] ref_add(logic [W-1:0] a, logic [W-1:0] b, logic ci);
        return {1'b0, a} + {1'b0, b} + {{W{1'b0}}, ci};
    endfunction

    function automatic exp_t model(logic [W-1:0] a, logic [W-1:0] b, logic [3:0] f,
                                   logic ce, logic [1:0] s, logic ci, string tag);
        exp_t e;
        logic [W:0] full;
        logic [W-1:0] lg;
        for (int i = 0; i < W; i++) lg[i] = f[{a[i], b[i]}];
        full = ref_add(a, b, ci);
        e.co = ce ? full[W] : (a[W-1] & b[W-1]);
        case (s)
            2'b00:   e.res = ce ? full[W-1:0] : (a ^ b);
            2'b01:   e.res = lg;
            2'b10:   e.res = a;
            default: e.res = b;
        endcase
        e.tag = tag;
        return e;
    endfunction

    task automatic drive(logic [W-1:0] a, logic [W-1:0] b, logic [3:0] f,
                         logic ce, logic [1:0] s, logic ci, string tag);
        @(posedge clk);
        op_a = a; op_b = b; func = f; carry_en = ce; res_sel = s; carry_in = ci;
        q.push_back(model(a, b, f, ce, s, ci, tag));
    endtask

    // Monitor: one expected item per cycle, compared mid-cycle
    initial begin
        forever begin
            @(negedge clk);
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                checks++;
                if (result !== e.res || carry_out !== e.co) begin
                    errors++;
                    $display("FAIL %s: result=%h carry_out=%b expected result=%h carry_out=%b",
                             e.tag, result, carry_out, e.res, e.co);
                end
            end
        end
    end

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not end, actual=hung expected=done");
            finish_run();
        end
    end

    initial begin
        repeat (2) @(posedge clk);
        rst = 1'b0;
        // reset-state style check: idle inputs give zero
        drive('0, '0, 4'h0, 1'b0, 2'b00, 1'b0, "R3 idle zero");
        // R1 / R2 corners
        drive(16'hFFFF, 16'h0001, 4'h0, 1'b1, 2'b00, 1'b0, "R1 R2 wrap");
        drive(16'hFFFF, 16'h0000, 4'h0, 1'b1, 2'b00, 1'b1, "R1 R2 carry_in ripple");
        drive(16'h7FFF, 16'h0001, 4'h0, 1'b1, 2'b00, 1'b0, "R1 mid ripple");
        drive(16'hFFFF, 16'hFFFF, 4'h0, 1'b1, 2'b00, 1'b1, "R1 R2 max");
        // R3 / R4 carry blocked against carry_in=1
        drive(16'hFFFF, 16'h0001, 4'h0, 1'b0, 2'b00, 1'b1, "R3 xor blocked");
        drive(16'h8000, 16'h8000, 4'h0, 1'b0, 2'b00, 1'b1, "R4 top generate");
        drive(16'h7FFF, 16'h7FFF, 4'h0, 1'b0, 2'b00, 1'b1, "R4 no propagate");
        // R6 constants
        drive(16'hA5C3, 16'h5A3C, 4'b0000, 1'b1, 2'b01, 1'b0, "R6 const zero");
        drive(16'h1234, 16'hFEDC, 4'b1111, 1'b0, 2'b01, 1'b1, "R6 const one");
        // R9 named functions
        drive(16'hF0F0, 16'hCCCC, 4'b1000, 1'b1, 2'b01, 1'b0, "R9 and");
        drive(16'hF0F0, 16'hCCCC, 4'b1110, 1'b1, 2'b01, 1'b0, "R9 or");
        drive(16'hF0F0, 16'hCCCC, 4'b0110, 1'b1, 2'b01, 1'b0, "R9 xor");
        drive(16'hF0F0, 16'hCCCC, 4'b1100, 1'b1, 2'b01, 1'b0, "R9 pass a code");
        drive(16'hF0F0, 16'hCCCC, 4'b1010, 1'b1, 2'b01, 1'b0, "R9 pass b code");
        drive(16'hF0F0, 16'hCCCC, 4'b0100, 1'b1, 2'b01, 1'b0, "R5 index order a-high");
        // R7 pass-through, R8 flag under other selections
        drive(16'h8001, 16'h8002, 4'h3, 1'b1, 2'b10, 1'b0, "R7 R8 pass a");
        drive(16'h8001, 16'h8002, 4'h3, 1'b0, 2'b11, 1'b1, "R7 R8 pass b");
        drive(16'hFFFF, 16'h0001, 4'h9, 1'b1, 2'b01, 1'b0, "R8 flag under logic");
        // Random sweep over every field
        for (int n = 0; n < 600; n++) begin
            logic [W-1:0] a, b;
            logic [3:0] f;
            logic [1:0] s;
            logic ce, ci;
            a = W'($urandom); b = W'($urandom); f = 4'($urandom);
            s = 2'($urandom); ce = 1'($urandom); ci = 1'($urandom);
            if (s == 2'b00) drive(a, b, f, ce, s, ci, ce ? "R1 R2 random add" : "R3 R4 random xor");
            else if (s == 2'b01) drive(a, b, f, ce, s, ci, "R5 R8 random logic");
            else drive(a, b, f, ce, s, ci, "R7 R8 random pass");
        end
        @(posedge clk);
        @(posedge clk);
        wait (q.size() == 0);
        @(posedge clk);
        done = 1;
        finish_run();
    end
endmodule